// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the 8-bit status register of a UART-style serial port, accessed by a CPU through a simple register bus. It holds five sticky flags (transmit buffer empty, receive buffer full, overrun, framing error, parity error). It also holds two bits that mirror datapath levels (transmission finished, received multiprocessor bit) and one plain read/write bit (multiprocessor bit to transmit). The receive and transmit datapaths raise the sticky flags through single-cycle event strobes.

The CPU can clear a sticky flag only in two steps. First it reads the register while that flag is 1, which arms the flag. Then its next register write carries a 0 in that flag's position. A write of 1 never sets a sticky flag. Any write uses up every armed flag, whatever value it carries. The transmit-empty flag is also cleared when the CPU loads the transmit data register. It is set when that data moves on to the shift register, and it is held set while transmission is disabled. A low-power input returns the whole register to its reset contents.

Top module: `sci_status_reg`

## Requirements
- R1: After reset the register reads 0x84. The bit layout, from bit 7 down to bit 0, is: transmit-empty, receive-full, overrun, framing error, parity error, transmit-end, received multiprocessor bit, transmit multiprocessor bit.
- R2: When `lowpwr_i` is high at a clock edge, the register reads 0x84 after that edge and every armed flag is disarmed.
- R3: A one-cycle pulse on `rx_full_set_i`, `overrun_set_i`, `frame_err_set_i` or `parity_err_set_i` sets bit 6, 5, 4 or 3 respectively from the next clock edge.
- R4: A register write with a 0 in a sticky bit (bits 7..3) clears that bit if a register read since the previous write returned 1 in that bit.
- R5: A write of 0 to a sticky bit that is not armed leaves it unchanged. Every write disarms all flags, so a second write needs a fresh read.
- R6: A write of 1 to a sticky bit has no effect on it.
- R7: When a set event and an armed write-0 clear hit the same bit in the same cycle, the bit ends up set.
- R8: Bit 7 is set by a `tdr_load_i` pulse and is held at 1 while `tx_en_i` is low. A `tdr_wr_i` pulse clears it when neither set condition is present.
- R9: Bit 2 follows `tx_end_i` and bit 1 follows `mpb_rx_i`, each one clock later. Register writes do not change them.
- R10: Bit 0 takes `wr_data_i[0]` on every register write and keeps its value otherwise.
- R11: `rd_data_o` always shows the current register contents, in the same cycle as `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lowpwr_i | input | 1 | Low-power mode; forces the reset contents |
| rd_en_i | input | 1 | CPU register read strobe |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_data_i | input | 8 | CPU write data |
| rd_data_o | output | 8 | Register contents |
| tdr_wr_i | input | 1 | CPU wrote the transmit data register |
| tdr_load_i | input | 1 | Transmit data moved to the shift register |
| tx_en_i | input | 1 | Transmitter enable |
| rx_full_set_i | input | 1 | Receive buffer loaded strobe |
| overrun_set_i | input | 1 | Overrun strobe |
| frame_err_set_i | input | 1 | Framing error strobe |
| parity_err_set_i | input | 1 | Parity error strobe |
| tx_end_i | input | 1 | Transmission finished level |
| mpb_rx_i | input | 1 | Received multiprocessor bit level |

## Verification
The hardest case to reach is a hardware event landing on the same bit in the same cycle as an armed write-0 clear. It only arises after a read has armed the flag. The stimulus first reads the register with the flag set, then drives the write strobe and the event strobe on the same falling edge. A further unarmed write shows that the arm was used up. Arm consumption and disarming by low-power mode are also only visible indirectly: the flag is set again, and a write of 0 must then leave it alone.

// File: rtl/sci_status_reg.sv
module sci_status_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = 8'h84
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lowpwr_i,
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  input  logic         tdr_wr_i,
  input  logic         tdr_load_i,
  input  logic         tx_en_i,
  input  logic         rx_full_set_i,
  input  logic         overrun_set_i,
  input  logic         frame_err_set_i,
  input  logic         parity_err_set_i,
  input  logic         tx_end_i,
  input  logic         mpb_rx_i
);

  localparam int NS = 5;
  localparam int SLO = W - NS;

  logic [NS-1:0] sticky_q, arm_q;
  logic          tend_q, mpbr_q, mpbt_q;

  logic [NS-1:0] set_ev, clr_ev;

  assign set_ev = {tdr_load_i | ~tx_en_i, rx_full_set_i, overrun_set_i,
                   frame_err_set_i, parity_err_set_i};

  assign clr_ev = ({NS{wr_en_i}} & arm_q & ~wr_data_i[W-1:SLO])
                | {tdr_wr_i, {(NS-1){1'b0}}};

  assign rd_data_o = {sticky_q, tend_q, mpbr_q, mpbt_q};

  always_ff @(posedge clk) begin
    if (!rst_n || lowpwr_i) begin
      sticky_q <= RST_VAL[W-1:SLO];
      tend_q   <= RST_VAL[2];
      mpbr_q   <= RST_VAL[1];
      mpbt_q   <= RST_VAL[0];
      arm_q    <= '0;
    end else begin
      sticky_q <= set_ev | (sticky_q & ~clr_ev);
      tend_q   <= tx_end_i;
      mpbr_q   <= mpb_rx_i;
      if (wr_en_i) begin
        mpbt_q <= wr_data_i[0];
        arm_q  <= '0;
      end else if (rd_en_i) begin
        arm_q  <= arm_q | sticky_q;
      end
    end
  end

endmodule

module sci_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lowpwr_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       tdr_load_i,
  input logic       tx_en_i,
  input logic       rx_full_set_i,
  input logic       overrun_set_i,
  input logic       tx_end_i,
  input logic       mpb_rx_i
);

  // R2
  lowpwr_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr_i |=> rd_data_o == 8'h84);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_set_i && !lowpwr_i) |=> rd_data_o[6]);

  // R3
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_set_i && !lowpwr_i) |=> rd_data_o[5]);

  // R6
  write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[4] && rd_data_o[4] && !lowpwr_i) |=> rd_data_o[4]);

  // R5
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data_o[6]) |-> ($past(lowpwr_i) || ($past(wr_en_i) && !$past(wr_data_i[6]))));

  // R8
  tdre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tdr_load_i || !tx_en_i) |=> rd_data_o[7]);

  // R9
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lowpwr_i |=> (rd_data_o[2] == $past(tx_end_i)) && (rd_data_o[1] == $past(mpb_rx_i)));

  // R10
  mpbt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !lowpwr_i) |=> rd_data_o[0] == $past(wr_data_i[0]));

endmodule

bind sci_status_reg sci_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lowpwr_i(lowpwr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .tdr_load_i(tdr_load_i),
  .tx_en_i(tx_en_i), .rx_full_set_i(rx_full_set_i), .overrun_set_i(overrun_set_i),
  .tx_end_i(tx_end_i), .mpb_rx_i(mpb_rx_i)
);

// File: tb/sci_status_reg_tb.sv
module sci_status_reg_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lowpwr_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       tdr_wr_i = 1'b0;
  logic       tdr_load_i = 1'b0;
  logic       tx_en_i = 1'b1;
  logic       rx_full_set_i = 1'b0;
  logic       overrun_set_i = 1'b0;
  logic       frame_err_set_i = 1'b0;
  logic       parity_err_set_i = 1'b0;
  logic       tx_end_i = 1'b1;
  logic       mpb_rx_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sci_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .lowpwr_i(lowpwr_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .tdr_wr_i(tdr_wr_i), .tdr_load_i(tdr_load_i), .tx_en_i(tx_en_i),
    .rx_full_set_i(rx_full_set_i), .overrun_set_i(overrun_set_i),
    .frame_err_set_i(frame_err_set_i), .parity_err_set_i(parity_err_set_i),
    .tx_end_i(tx_end_i), .mpb_rx_i(mpb_rx_i)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic bus_read(output logic [7:0] d);
    rd_en_i = 1'b1;
    #1 d = rd_data_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", rd_data_o, 8'h84);
  endtask

  task automatic t_rx_set();
    rx_full_set_i = 1'b1;
    @(negedge clk);
    rx_full_set_i = 1'b0;
    check("R3 rx full", rd_data_o, 8'hC4);
    overrun_set_i = 1'b1; frame_err_set_i = 1'b1; parity_err_set_i = 1'b1;
    @(negedge clk);
    overrun_set_i = 1'b0; frame_err_set_i = 1'b0; parity_err_set_i = 1'b0;
    check("R3 errors", rd_data_o, 8'hFC);
  endtask

  task automatic t_write_one();
    bus_write(8'hFE);
    check("R6 write one", rd_data_o, 8'hFC);
  endtask

  task automatic t_unarmed();
    bus_write(8'h00);
    check("R5 R9 unarmed write0", rd_data_o, 8'hFC);
  endtask

  task automatic t_armed();
    logic [7:0] d;
    bus_read(d);
    check("R11 read data", d, 8'hFC);
    bus_write(8'h00);
    check("R4 armed clear", rd_data_o, 8'h04);
  endtask

  task automatic t_consume();
    logic [7:0] d;
    rx_full_set_i = 1'b1;
    @(negedge clk);
    rx_full_set_i = 1'b0;
    bus_read(d);
    bus_write(8'hFF);
    check("R6 R10 write one armed", rd_data_o, 8'h45);
    bus_write(8'hFE);
    check("R5 arm consumed", rd_data_o, 8'h44);
    bus_read(d);
    bus_write(8'h00);
    check("R4 clear after reread", rd_data_o, 8'h04);
  endtask

  task automatic t_selective();
    logic [7:0] d;
    overrun_set_i = 1'b1; frame_err_set_i = 1'b1;
    @(negedge clk);
    overrun_set_i = 1'b0; frame_err_set_i = 1'b0;
    bus_read(d);
    bus_write(8'h20);
    check("R4 selective clear", rd_data_o, 8'h24);
    bus_read(d);
    bus_write(8'h00);
    check("R4 clear rest", rd_data_o, 8'h04);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    parity_err_set_i = 1'b1;
    @(negedge clk);
    parity_err_set_i = 1'b0;
    bus_read(d);
    parity_err_set_i = 1'b1;
    bus_write(8'h00);
    parity_err_set_i = 1'b0;
    check("R7 set wins", rd_data_o, 8'h0C);
    bus_write(8'h00);
    check("R5 R7 arm used", rd_data_o, 8'h0C);
    bus_read(d);
    bus_write(8'h00);
    check("R4 parity clear", rd_data_o, 8'h04);
  endtask

  task automatic t_tdre();
    tdr_load_i = 1'b1;
    @(negedge clk);
    tdr_load_i = 1'b0;
    check("R8 load sets", rd_data_o, 8'h84);
    tdr_wr_i = 1'b1;
    @(negedge clk);
    tdr_wr_i = 1'b0;
    check("R8 tdr write clears", rd_data_o, 8'h04);
    tx_en_i = 1'b0;
    @(negedge clk);
    check("R8 disable sets", rd_data_o, 8'h84);
    tdr_wr_i = 1'b1;
    @(negedge clk);
    tdr_wr_i = 1'b0;
    check("R8 held while disabled", rd_data_o, 8'h84);
    tx_en_i = 1'b1;
    tdr_wr_i = 1'b1;
    @(negedge clk);
    tdr_wr_i = 1'b0;
    check("R8 clear when enabled", rd_data_o, 8'h04);
  endtask

  task automatic t_levels();
    mpb_rx_i = 1'b1;
    @(negedge clk);
    check("R9 mpbr follows", rd_data_o, 8'h06);
    tx_end_i = 1'b0;
    @(negedge clk);
    check("R9 tend follows", rd_data_o, 8'h02);
    bus_write(8'h07);
    check("R9 R10 write ignored levels", rd_data_o, 8'h03);
    tx_end_i = 1'b1; mpb_rx_i = 1'b0;
    @(negedge clk);
    check("R10 mpbt held", rd_data_o, 8'h05);
    bus_write(8'h00);
    check("R10 mpbt cleared", rd_data_o, 8'h04);
  endtask

  task automatic t_lowpwr();
    logic [7:0] d;
    rx_full_set_i = 1'b1;
    @(negedge clk);
    rx_full_set_i = 1'b0;
    bus_write(8'h01);
    check("R3 R10 before lowpwr", rd_data_o, 8'h45);
    bus_read(d);
    lowpwr_i = 1'b1;
    @(negedge clk);
    lowpwr_i = 1'b0;
    check("R2 lowpwr restores", rd_data_o, 8'h84);
    rx_full_set_i = 1'b1;
    @(negedge clk);
    rx_full_set_i = 1'b0;
    bus_write(8'h00);
    check("R2 arm dropped", rd_data_o, 8'hC4);
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_set();
    t_write_one();
    t_unarmed();
    t_armed();
    t_consume();
    t_selective();
    t_set_wins();
    t_tdre();
    t_levels();
    t_lowpwr();
    summary();
  end

endmodule